// File: doc/BRIEF.md
# Two-Bank SDRAM Command Spacing Monitor

This block sits beside the command bus of a two-bank, 16-bit synchronous DRAM and reports every command that arrives sooner than the device allows. It never drives the bus. On each rising clock edge where clock enable is high, it decodes the command and bank inputs. It keeps one recovery state machine per bank plus a few spacing counters, and it raises one violation bit per rule in the cycle after the offending edge. A sticky summary flag records that some rule was broken and stays set until software or a test harness clears it.

Limits given in nanoseconds are turned into clock counts at elaboration as ceil(limit / CLK_NS). Cycle-counted spacings advance only on edges where cke is high. A clock-hold period therefore stretches every window except the refresh interval, which is wall-clock time. The read latency (2 or 3) is a live configuration input. It moves the window in which read data occupies the data bus and the point at which a deactivate cuts that data off.

Each bank runs a three-state machine: BK_IDLE, BK_OPEN and BK_RECOV. An activate takes BK_IDLE to BK_OPEN. A read or write with auto-precharge takes BK_IDLE or BK_OPEN to BK_RECOV, which loads the recovery count. A deactivate (bank-specific or all-bank) takes BK_OPEN back to BK_IDLE. BK_RECOV returns to BK_IDLE once the recovery count completes, and it ignores every command until then.

Top module: `sdram_cmd_timing_chk`

## Requirements
- R1: After reset, viol_o and sticky_o are zero. No check is armed until the command that starts it has been seen.
- R2: The command codes are 0 deselect, 1 activate, 2 read, 3 write, 4 read with auto-precharge, 5 write with auto-precharge, 6 deactivate, 7 deactivate-all, 8 mode-register set, 9 refresh and 10 mask/enable. A command takes effect only at an edge with cke=1. The gap between two commands is the number of cke=1 edges between them.
- R3: An activate to one bank less than ceil(TRRD_NS/CLK_NS) gaps after the last activate to the other bank sets viol_o bit 0.
- R4: A deactivate to bank b, or a deactivate-all, less than ceil(TRWL_NS/CLK_NS)+BURST-1 gaps after a write (code 3 or 5) to that bank sets viol_o bit 1.
- R5: An activate, refresh or mode-register set less than 2 gaps after a mode-register set sets viol_o bit 2.
- R6: A read or write with auto-precharge puts its bank in recovery for ceil(TRP_NS/CLK_NS)+BURST gaps. An activate, refresh or mode-register set issued while either bank is in recovery sets viol_o bit 3.
- R7: A read (code 2 or 4) at edge t drives read data at edges t+L through t+L+BURST-1, where L=2 when rd_lat3=0 and L=3 when rd_lat3=1. A write at one of those edges sets viol_o bit 4.
- R8: A deactivate to the bank of the most recent read, or a deactivate-all, at edge d ends read data after edge d+L-1. A deactivate to the other bank leaves that read data unchanged.
- R9: After a refresh, if no further refresh arrives within ceil(TREF_NS/CLK_NS) clock edges (all edges, whatever cke is), viol_o bit 5 pulses once at that edge. The refresh check then stays disarmed until the next refresh.
- R10: viol_o shows the violations of the previous edge. sticky_o is set by any violation and is cleared by clr_sticky, except when a violation occurs at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable of the memory; low means hold |
| cmd | input | 4 | Decoded command code (see R2) |
| bank | input | 1 | Bank address of the command |
| rd_lat3 | input | 1 | Read latency select: 0 for 2, 1 for 3 |
| clr_sticky | input | 1 | Synchronous clear of the summary flag |
| viol_o | output | 6 | Per-rule violation pulses (bits per R3 to R9) |
| sticky_o | output | 1 | Sticky violation summary |

## Verification
The bench aims at the exact boundary of each window: one gap short of the limit and exactly at it. A design that is off by one either misses the late command or flags a legal one. It holds cke low between commands to catch counters that keep advancing during a clock hold. It also cuts read bursts with a deactivate at both latencies, and issues a deactivate to the wrong bank, so that a tracker that ignores latency or bank flags good writes or lets contention pass. The refresh test places the second refresh exactly on the deadline, then lets the deadline lapse, to show the interval is inclusive and that the timeout pulses only once. Random traffic with latency sections and random clears covers the rest, including a clear at the same edge as a violation.

// File: rtl/sdtc_pkg.sv
package sdtc_pkg;

    typedef enum logic [3:0] {
        CMD_DESL = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_RDA  = 4'd4,
        CMD_WRA  = 4'd5,
        CMD_DEAC = 4'd6,
        CMD_DCAB = 4'd7,
        CMD_MRS  = 4'd8,
        CMD_REF  = 4'd9,
        CMD_MASK = 4'd10
    } sd_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_RECOV = 2'd2
    } bank_state_e;

    localparam int RULE_RRD  = 0;
    localparam int RULE_WRL  = 1;
    localparam int RULE_MRS  = 2;
    localparam int RULE_APR  = 3;
    localparam int RULE_BUS  = 4;
    localparam int RULE_REF  = 5;
    localparam int NUM_RULES = 6;

    // Nanosecond limit rounded up to whole clocks.
    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

endpackage

// File: rtl/sdtc_gap.sv
// Counts enabled edges since the last start; short_o is high while the
// gap seen at the current edge is below LIMIT. Zero means disarmed.
module sdtc_gap #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic short_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign short_o = (cnt_q != '0) && (cnt_q < CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (start)
                cnt_q <= CW'(1);
            else if (short_o)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdtc_bank.sv
module sdtc_bank
    import sdtc_pkg::*;
#(
    parameter int RRD_CYC = 3,
    parameter int WRL_CYC = 4,
    parameter int APR_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic act_i,
    input  logic ap_i,
    input  logic wr_i,
    input  logic deac_i,
    output logic act_short_o,
    output logic wr_short_o,
    output logic recov_o
);
    localparam int AW = $clog2(APR_CYC + 1);

    bank_state_e   st_q, st_d;
    logic [AW-1:0] ap_cnt_q, ap_cnt_d;

    sdtc_gap #(.LIMIT(RRD_CYC)) u_act_gap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(act_i), .short_o(act_short_o)
    );

    sdtc_gap #(.LIMIT(WRL_CYC)) u_wr_gap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(wr_i), .short_o(wr_short_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= BK_IDLE;
            ap_cnt_q <= '0;
        end else begin
            st_q     <= st_d;
            ap_cnt_q <= ap_cnt_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        ap_cnt_d = ap_cnt_q;
        if (tick) begin
            unique case (st_q)
                BK_IDLE: begin
                    if (ap_i) begin
                        st_d     = BK_RECOV;
                        ap_cnt_d = AW'(1);
                    end else if (act_i) begin
                        st_d = BK_OPEN;
                    end
                end
                BK_OPEN: begin
                    if (ap_i) begin
                        st_d     = BK_RECOV;
                        ap_cnt_d = AW'(1);
                    end else if (deac_i) begin
                        st_d = BK_IDLE;
                    end
                end
                BK_RECOV: begin
                    if (ap_cnt_q >= AW'(APR_CYC - 1)) begin
                        st_d     = BK_IDLE;
                        ap_cnt_d = '0;
                    end else begin
                        ap_cnt_d = ap_cnt_q + 1'b1;
                    end
                end
                default: st_d = BK_IDLE;
            endcase
        end
    end

    always_comb begin
        recov_o = (st_q == BK_RECOV);
    end
endmodule

// File: rtl/sdtc_dq.sv
// Read-data occupancy of the data bus, one bit per future enabled edge.
module sdtc_dq #(
    parameter int BURST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rd_i,
    input  logic bank_i,
    input  logic deac_i,
    input  logic dcab_i,
    input  logic lat3_i,
    output logic busy_o
);
    localparam int MAX_LAT = 3;
    localparam int W       = MAX_LAT + BURST;

    logic [W-1:0] occ_q, occ_m, rd_bits, keep_bits;
    logic [1:0]   lat;
    logic         rd_bank_q, cut;

    always_comb begin
        lat       = lat3_i ? 2'd3 : 2'd2;
        rd_bits   = W'((1 << BURST) - 1) << lat;
        keep_bits = ~({W{1'b1}} << lat);
        cut       = dcab_i || (deac_i && (bank_i == rd_bank_q));
        occ_m     = (cut ? (occ_q & keep_bits) : occ_q) | (rd_i ? rd_bits : '0);
        busy_o    = occ_q[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q     <= '0;
            rd_bank_q <= 1'b0;
        end else if (tick) begin
            occ_q <= occ_m >> 1;
            if (rd_i)
                rd_bank_q <= bank_i;
        end
    end
endmodule

// File: rtl/sdram_cmd_timing_chk.sv
module sdram_cmd_timing_chk
    import sdtc_pkg::*;
#(
    parameter int CLK_NS  = 10,
    parameter int TRRD_NS = 24,
    parameter int TRWL_NS = 24,
    parameter int TRP_NS  = 30,
    parameter int TREF_NS = 32000000,
    parameter int MRS_GAP = 2,
    parameter int BURST   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic [3:0]           cmd,
    input  logic                 bank,
    input  logic                 rd_lat3,
    input  logic                 clr_sticky,
    output logic [NUM_RULES-1:0] viol_o,
    output logic                 sticky_o
);
    localparam int NUM_BANKS = 2;
    localparam int RRD_CYC   = ns2cyc(TRRD_NS, CLK_NS);
    localparam int WRL_CYC   = ns2cyc(TRWL_NS, CLK_NS) + BURST - 1;
    // Both auto-precharge flavours land on precharge time plus the burst.
    localparam int APR_CYC   = ns2cyc(TRP_NS, CLK_NS) + BURST;
    localparam int REF_CYC   = ns2cyc(TREF_NS, CLK_NS);
    localparam int REF_W     = $clog2(REF_CYC + 1);

    sd_cmd_e cmd_e;
    logic is_act, is_rd, is_wr, is_rda, is_wra, is_deac, is_dcab, is_mrs, is_ref;
    logic [NUM_BANKS-1:0] act_short, wr_short, recov;
    logic mrs_short, dq_busy, ref_late, ref_armed;
    logic [REF_W-1:0] ref_cnt;
    logic [NUM_RULES-1:0] viol_next;

    assign cmd_e = sd_cmd_e'(cmd);

    always_comb begin
        {is_act, is_rd, is_wr, is_rda, is_wra, is_deac, is_dcab, is_mrs, is_ref} = '0;
        if (cke) begin
            case (cmd_e)
                CMD_ACT:  is_act  = 1'b1;
                CMD_RD:   is_rd   = 1'b1;
                CMD_WR:   is_wr   = 1'b1;
                CMD_RDA:  is_rda  = 1'b1;
                CMD_WRA:  is_wra  = 1'b1;
                CMD_DEAC: is_deac = 1'b1;
                CMD_DCAB: is_dcab = 1'b1;
                CMD_MRS:  is_mrs  = 1'b1;
                CMD_REF:  is_ref  = 1'b1;
                default:  ;
            endcase
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (bank == 1'(b));
        sdtc_bank #(
            .RRD_CYC(RRD_CYC), .WRL_CYC(WRL_CYC), .APR_CYC(APR_CYC)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (cke),
            .act_i      (is_act && sel),
            .ap_i       ((is_rda || is_wra) && sel),
            .wr_i       ((is_wr || is_wra) && sel),
            .deac_i     ((is_deac && sel) || is_dcab),
            .act_short_o(act_short[b]),
            .wr_short_o (wr_short[b]),
            .recov_o    (recov[b])
        );
    end

    sdtc_gap #(.LIMIT(MRS_GAP)) u_mrs_gap (
        .clk(clk), .rst_n(rst_n), .tick(cke), .start(is_mrs), .short_o(mrs_short)
    );

    sdtc_dq #(.BURST(BURST)) u_dq (
        .clk(clk), .rst_n(rst_n), .tick(cke), .rd_i(is_rd || is_rda),
        .bank_i(bank), .deac_i(is_deac), .dcab_i(is_dcab), .lat3_i(rd_lat3),
        .busy_o(dq_busy)
    );

    // Refresh interval runs on every clock, not only enabled ones.
    assign ref_late = ref_armed && (ref_cnt == REF_W'(REF_CYC)) && !is_ref;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt   <= '0;
            ref_armed <= 1'b0;
        end else if (is_ref) begin
            ref_cnt   <= REF_W'(1);
            ref_armed <= 1'b1;
        end else if (ref_late) begin
            ref_armed <= 1'b0;
        end else if (ref_armed) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    always_comb begin
        viol_next           = '0;
        viol_next[RULE_RRD] = is_act && act_short[~bank];
        viol_next[RULE_WRL] = (is_deac && wr_short[bank]) || (is_dcab && (|wr_short));
        viol_next[RULE_MRS] = (is_act || is_ref || is_mrs) && mrs_short;
        viol_next[RULE_APR] = (is_act || is_ref || is_mrs) && (|recov);
        viol_next[RULE_BUS] = (is_wr || is_wra) && dq_busy;
        viol_next[RULE_REF] = ref_late;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o   <= '0;
            sticky_o <= 1'b0;
        end else begin
            viol_o   <= viol_next;
            sticky_o <= (|viol_next) | (sticky_o & ~clr_sticky);
        end
    end
endmodule

// File: rtl/sdtc_chk.sv
module sdtc_chk
    import sdtc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic [3:0]           cmd,
    input logic                 clr_sticky,
    input logic [NUM_RULES-1:0] viol_o,
    input logic                 sticky_o
);
    localparam logic [NUM_RULES-1:0] CMD_RULES = ~(NUM_RULES'(1) << RULE_REF);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_o && !clr_sticky |=> sticky_o); // R10

    AST_VIOL_MARKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|viol_o) |-> sticky_o); // R10

    AST_HOLD_NO_CMD_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (viol_o & CMD_RULES) == '0); // R2

    AST_BUS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o[RULE_BUS] |-> $past(cke && (cmd == CMD_WR || cmd == CMD_WRA))); // R7

    AST_MRS_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cke && cmd == CMD_MRS) && cke &&
        (cmd == CMD_ACT || cmd == CMD_REF || cmd == CMD_MRS) |=> viol_o[RULE_MRS]); // R5

    AST_REF_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o[RULE_REF] |=> !viol_o[RULE_REF]); // R9
endmodule

bind sdram_cmd_timing_chk sdtc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .clr_sticky(clr_sticky),
    .viol_o(viol_o), .sticky_o(sticky_o)
);

// File: tb/sdram_cmd_timing_chk_tb.sv
module sdram_cmd_timing_chk_tb;
    import sdtc_pkg::*;

    localparam int TREF_NS = 500;
    localparam int BURST   = 2;
    localparam int RRD     = 3;   // ceil(24/10)
    localparam int WRL     = 4;   // ceil(24/10) + BURST - 1
    localparam int APR     = 5;   // ceil(30/10) + BURST
    localparam int MRSG    = 2;
    localparam int REFC    = 50;  // ceil(500/10)

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, cke, bank, rd_lat3, clr_sticky;
    logic [3:0] cmd;
    logic [NUM_RULES-1:0] viol_o;
    logic       sticky_o;

    sdram_cmd_timing_chk #(.TREF_NS(TREF_NS), .BURST(BURST)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank),
        .rd_lat3(rd_lat3), .clr_sticky(clr_sticky), .viol_o(viol_o), .sticky_o(sticky_o)
    );

    int nchk = 0, nfail = 0;
    int tk, ck, mrs_t, ref_t, wptr;
    int act_t[2], wr_t[2], apr_t[2], win_lo[4], win_hi[4];
    bit act_v[2], wr_v[2], apr_v[2];
    bit mrs_v, ref_v, sticky_m, last_rd_bank;

    function automatic void model_reset();
        tk = 0; ck = 0; wptr = 0; mrs_v = 0; ref_v = 0; sticky_m = 0; last_rd_bank = 0;
        for (int i = 0; i < 2; i++) begin act_v[i] = 0; wr_v[i] = 0; apr_v[i] = 0; end
        for (int i = 0; i < 4; i++) begin win_lo[i] = 1; win_hi[i] = 0; end
    endfunction

    function automatic void model_step(input logic c_cke, input logic [3:0] c_cmd,
                                       input logic c_bank, input logic c_lat3,
                                       input logic c_clr, output logic [NUM_RULES-1:0] e);
        int tn = tk + (c_cke ? 1 : 0);
        int cn = ck + 1;
        int b  = int'(c_bank);
        int o  = 1 - b;
        int lat = c_lat3 ? 3 : 2;
        bit act  = c_cke && c_cmd == CMD_ACT;
        bit rd   = c_cke && (c_cmd == CMD_RD || c_cmd == CMD_RDA);
        bit wr   = c_cke && (c_cmd == CMD_WR || c_cmd == CMD_WRA);
        bit ap   = c_cke && (c_cmd == CMD_RDA || c_cmd == CMD_WRA);
        bit deac = c_cke && c_cmd == CMD_DEAC;
        bit dcab = c_cke && c_cmd == CMD_DCAB;
        bit mrs  = c_cke && c_cmd == CMD_MRS;
        bit rf   = c_cke && c_cmd == CMD_REF;
        e = '0;
        if (act && act_v[o] && tn - act_t[o] < RRD) e[RULE_RRD] = 1;
        if (deac && wr_v[b] && tn - wr_t[b] < WRL) e[RULE_WRL] = 1;
        if (dcab) for (int i = 0; i < 2; i++)
            if (wr_v[i] && tn - wr_t[i] < WRL) e[RULE_WRL] = 1;
        if (act || rf || mrs) begin
            if (mrs_v && tn - mrs_t < MRSG) e[RULE_MRS] = 1;
            for (int i = 0; i < 2; i++)
                if (apr_v[i] && tn - apr_t[i] < APR) e[RULE_APR] = 1;
        end
        if (wr) for (int i = 0; i < 4; i++)
            if (tn >= win_lo[i] && tn <= win_hi[i]) e[RULE_BUS] = 1;
        if (ref_v && !rf && cn - ref_t == REFC) begin e[RULE_REF] = 1; ref_v = 0; end
        if (act) begin act_t[b] = tn; act_v[b] = 1; end
        if (wr)  begin wr_t[b] = tn; wr_v[b] = 1; end
        if (mrs) begin mrs_t = tn; mrs_v = 1; end
        if (ap && !(apr_v[b] && tn - apr_t[b] < APR)) begin apr_t[b] = tn; apr_v[b] = 1; end
        if ((deac && c_bank == last_rd_bank) || dcab)
            for (int i = 0; i < 4; i++)
                if (win_hi[i] > tn + lat - 1) win_hi[i] = tn + lat - 1;
        if (rd) begin
            win_lo[wptr] = tn + lat; win_hi[wptr] = tn + lat + BURST - 1;
            wptr = (wptr + 1) % 4; last_rd_bank = c_bank;
        end
        if (rf) begin ref_t = cn; ref_v = 1; end
        tk = tn; ck = cn;
        sticky_m = (|e) | (sticky_m & !c_clr);
    endfunction

    function automatic string tag_of(input logic [NUM_RULES-1:0] d);
        string tags[NUM_RULES] = '{"R3", "R4", "R5", "R6", "R7", "R9"};
        for (int i = 0; i < NUM_RULES; i++) if (d[i]) return tags[i];
        return "R10";
    endfunction

    task automatic step(input logic c_cke, input logic [3:0] c_cmd, input logic c_bank,
                        input logic c_clr, input string ctx);
        logic [NUM_RULES-1:0] e;
        cke = c_cke; cmd = c_cmd; bank = c_bank; clr_sticky = c_clr;
        model_step(c_cke, c_cmd, c_bank, rd_lat3, c_clr, e);
        @(posedge clk);
        @(negedge clk);
        nchk++;
        if (viol_o !== e || sticky_o !== sticky_m) begin
            nfail++;
            $display("FAIL %s %s: viol=%b expected %b sticky=%b expected %b",
                     ctx, tag_of(viol_o ^ e), viol_o, e, sticky_o, sticky_m);
        end
    endtask

    task automatic c(input logic [3:0] k, input logic b, input string ctx);
        step(1'b1, k, b, 1'b0, ctx);
    endtask

    task automatic idle(input int n, input string ctx);
        for (int i = 0; i < n; i++) step(1'b1, CMD_DESL, 1'b0, 1'b0, ctx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cke = 1'b1; cmd = CMD_DESL; bank = 1'b0; rd_lat3 = 1'b0; clr_sticky = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nchk++;
        if (viol_o !== '0 || sticky_o !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: viol=%b sticky=%b expected 0 0", viol_o, sticky_o);
        end
        // R1: first commands after reset find nothing armed
        c(CMD_MRS, 0, "R1"); idle(2, "R1");
        // R3: activate to other bank one gap late is short; gap of 3 is legal
        c(CMD_ACT, 0, "R3"); c(CMD_ACT, 1, "R3"); idle(2, "R3");
        c(CMD_ACT, 0, "R3"); c(CMD_ACT, 0, "R3"); idle(1, "R3");
        c(CMD_ACT, 1, "R3");
        step(1'b1, CMD_DESL, 0, 1'b1, "R10"); idle(4, "R3");
        // R2: hold cycles do not count, a command with cke low is ignored
        c(CMD_ACT, 1, "R2");
        for (int i = 0; i < 5; i++) step(1'b0, CMD_ACT, 0, 1'b0, "R2");
        c(CMD_ACT, 0, "R2"); idle(4, "R2");
        // R4: write recovery before deactivate
        c(CMD_WR, 0, "R4"); idle(1, "R4"); c(CMD_DEAC, 0, "R4");
        c(CMD_WR, 1, "R4"); idle(3, "R4"); c(CMD_DEAC, 1, "R4");
        c(CMD_WR, 0, "R4"); c(CMD_DCAB, 1, "R4"); idle(4, "R4");
        // R5: mode-register spacing
        c(CMD_MRS, 0, "R5"); c(CMD_MRS, 0, "R5"); idle(1, "R5"); c(CMD_ACT, 0, "R5");
        c(CMD_MRS, 0, "R5"); idle(1, "R5"); c(CMD_REF, 0, "R5"); idle(4, "R5");
        // R6: auto-precharge recovery, one short and exactly on the limit
        c(CMD_ACT, 0, "R6"); c(CMD_RDA, 0, "R6"); idle(3, "R6"); c(CMD_ACT, 1, "R6");
        idle(6, "R6");
        c(CMD_ACT, 0, "R6"); c(CMD_WRA, 0, "R6"); idle(4, "R6"); c(CMD_MRS, 0, "R6");
        idle(6, "R6");
        // R7: read data window at latency 2
        c(CMD_RD, 0, "R7"); idle(1, "R7"); c(CMD_WR, 1, "R7"); idle(4, "R7");
        c(CMD_RD, 0, "R7"); idle(3, "R7"); c(CMD_WR, 0, "R7"); idle(4, "R7");
        c(CMD_RD, 0, "R7"); c(CMD_WR, 0, "R7"); idle(6, "R7");
        // R8: deactivate cut-off, matching and other bank
        c(CMD_RD, 0, "R8"); c(CMD_DEAC, 0, "R8"); idle(1, "R8"); c(CMD_WR, 0, "R8"); idle(6, "R8");
        c(CMD_RD, 0, "R8"); c(CMD_DEAC, 1, "R8"); idle(1, "R8"); c(CMD_WR, 0, "R8"); idle(6, "R8");
        rd_lat3 = 1'b1;
        c(CMD_RD, 1, "R8"); c(CMD_DCAB, 0, "R8"); idle(1, "R8"); c(CMD_WR, 1, "R8"); idle(6, "R8");
        c(CMD_RD, 1, "R7"); idle(1, "R7"); c(CMD_WR, 0, "R7"); c(CMD_WR, 0, "R7"); idle(6, "R7");
        rd_lat3 = 1'b0;
        // R9: refresh exactly at the deadline is legal, a missed one pulses once
        c(CMD_REF, 0, "R9"); idle(REFC - 1, "R9"); c(CMD_REF, 0, "R9");
        idle(REFC + 4, "R9");
        // R10: clear at the same edge as a violation keeps the flag
        c(CMD_MRS, 0, "R10"); step(1'b1, CMD_MRS, 0, 1'b1, "R10");
        step(1'b1, CMD_DESL, 0, 1'b1, "R10"); idle(3, "R10");
        // Random traffic, one latency per section
        for (int s = 0; s < 2; s++) begin
            rd_lat3 = s[0];
            for (int i = 0; i < 2000; i++) begin
                int r = $urandom_range(0, 19);
                step(($urandom_range(0, 9) != 0), (r <= 10) ? 4'(r) : 4'(CMD_DESL),
                     1'($urandom_range(0, 1)), ($urandom_range(0, 49) == 0), "random");
            end
            idle(8, "random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule